// File: doc/BRIEF.md
# Oscillator Mode Clock Controller

This block picks the core clock for a microcontroller from one of three sources (an external clock, a crystal-derived clock, or a PLL that runs at four times the crystal) according to a 3-bit oscillator mode field. The field is fixed when the part is programmed. The block also decides how the secondary oscillator pin is used. In external-clock modes the pin either carries the core clock divided by four or is handed over to general-purpose I/O. A run-enable output holds execution back until the start-up conditions for the selected mode are met.

Start-up is sequenced by a small state machine clocked from a free-running reference clock. There are three start-up cases:
- External-clock modes start at once.
- Crystal modes wait for an oscillator start-up count.
- PLL mode waits for a lock count and then for the lock indication.

The same rule applies after a power-on reset and after a wake from sleep.

The state machine has these states: `ST_RESET` (power-on reset held), `ST_OST_WAIT` (crystal start-up count), `ST_LOCK_WAIT` (PLL lock count and lock indication), `ST_RUN` (execution allowed) and `ST_SLEEP` (sleeping). Its transitions are:
- Reset release, or a wake event in `ST_SLEEP`, goes to `ST_RUN`, `ST_OST_WAIT` or `ST_LOCK_WAIT`, depending on the mode.
- `ST_OST_WAIT` goes to `ST_RUN` when its count ends.
- `ST_LOCK_WAIT` goes to `ST_RUN` when its count has ended and lock is reported.
- `ST_RUN` goes to `ST_SLEEP` on a sleep request.
- Power-on reset sends any state to `ST_RESET`.

Top module: `osc_mode_clkctl`

## Requirements
- R1: The mode field is captured on every reference-clock edge while `por_n` is low. Changes to it after reset release alter neither the clock source, nor `pll_en`, nor `osc2_is_gpio`.
- R2: The core clock follows the mode. Mode codes 3'b100 and 3'b101 select `clk_ext`. Mode code 3'b010 selects `clk_pll`. Every other code (3'b000, 3'b001, 3'b011, 3'b110, 3'b111) selects `clk_xtal`.
- R3: `pll_en` is high only for mode code 3'b010. It is low for every other code.
- R4: In mode 3'b100, `osc2_clk` is the core clock divided by four with 50% duty: high for two core cycles, then low for two. It is low while reset is held.
- R5: In mode 3'b101, `osc2_is_gpio` is 1 and `osc2_clk` stays low. In every other mode `osc2_is_gpio` is 0, and `osc2_clk` is low in every mode except 3'b100.
- R6: In modes 3'b100 and 3'b101, `run_en` rises one reference edge after reset release or after a wake event, with no start-up wait.
- R7: In crystal modes without the PLL (all codes that select `clk_xtal`), `run_en` rises `OST_CYCLES`+1 reference edges after reset release or a wake event.
- R8: In mode 3'b010, `run_en` rises `LOCK_CYCLES`+1 reference edges after reset release or a wake event if `pll_locked` is high. If `pll_locked` is low, `run_en` stays low until the first edge at which `pll_locked` is high, after the count has ended.
- R9: A `sleep_req` sampled high while running drops `run_en` on that edge. A later `wake_evt` restarts the mode's start-up wait.
- R10: `run_en` is low while `por_n` is low.
- R11: `wake_evt` while running does not drop `run_en`. `sleep_req` while sleeping leaves the block asleep with `run_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for the start-up sequencer and for mode capture |
| por_n | input | 1 | Power-on reset, active low |
| cfg_mode | input | 3 | Oscillator mode field |
| clk_ext | input | 1 | External clock input |
| clk_xtal | input | 1 | Crystal-derived clock |
| clk_pll | input | 1 | PLL output clock (four times crystal) |
| pll_locked | input | 1 | PLL lock indication |
| sleep_req | input | 1 | Sleep request, synchronous to ref_clk |
| wake_evt | input | 1 | Wake event, synchronous to ref_clk |
| core_clk | output | 1 | Selected core clock |
| osc2_clk | output | 1 | Divide-by-four clock for the secondary pin |
| osc2_is_gpio | output | 1 | Secondary pin handed to general-purpose I/O (port bit 6) |
| pll_en | output | 1 | PLL enable |
| run_en | output | 1 | Execution allowed |

## Verification
Every mode code class is powered up in turn: external with clock out, external with I/O, PLL with lock present, PLL with lock withheld past the count, the two crystal codes, and an unused code. Each run measures the run-enable latency and compares the core clock against each source at many off-edge instants; this tells a wrong source or a wrong wait apart from a correct one. Sleep and wake cycles repeat the latency measurement in each wait class. Stray sleep and wake pulses in the wrong state, and mode-field changes after reset, are each applied between the regular steps to show they are ignored. The divider output is sampled on the falling core edge across several periods, which separates a divide-by-four with the right duty from a wrong ratio or phase.

// File: rtl/osc_clkctl_pkg.sv
package osc_clkctl_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_XTAL_LO   = 3'b000;
    localparam logic [MODE_W-1:0] MODE_XTAL_HI   = 3'b001;
    localparam logic [MODE_W-1:0] MODE_XTAL_PLL  = 3'b010;
    localparam logic [MODE_W-1:0] MODE_EXT_CKOUT = 3'b100;
    localparam logic [MODE_W-1:0] MODE_EXT_GPIO  = 3'b101;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_PLL  = 2'd2
    } clk_src_e;

    typedef enum logic [1:0] {
        WAIT_NONE = 2'd0,
        WAIT_OST  = 2'd1,
        WAIT_LOCK = 2'd2
    } start_wait_e;

    typedef enum logic [2:0] {
        ST_RESET     = 3'd0,
        ST_OST_WAIT  = 3'd1,
        ST_LOCK_WAIT = 3'd2,
        ST_RUN       = 3'd3,
        ST_SLEEP     = 3'd4
    } seq_state_e;

    typedef struct packed {
        clk_src_e    src;
        start_wait_e wait_kind;
        logic        pll_en;
        logic        osc2_clkout;
        logic        osc2_gpio;
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        mode_cfg_t c;
        c.src         = SRC_XTAL;
        c.wait_kind   = WAIT_OST;
        c.pll_en      = 1'b0;
        c.osc2_clkout = 1'b0;
        c.osc2_gpio   = 1'b0;
        unique case (m)
            MODE_XTAL_LO, MODE_XTAL_HI: begin
                c.src       = SRC_XTAL;
                c.wait_kind = WAIT_OST;
            end
            MODE_XTAL_PLL: begin
                c.src       = SRC_PLL;
                c.wait_kind = WAIT_LOCK;
                c.pll_en    = 1'b1;
            end
            MODE_EXT_CKOUT: begin
                c.src         = SRC_EXT;
                c.wait_kind   = WAIT_NONE;
                c.osc2_clkout = 1'b1;
            end
            MODE_EXT_GPIO: begin
                c.src       = SRC_EXT;
                c.wait_kind = WAIT_NONE;
                c.osc2_gpio = 1'b1;
            end
            default: begin
                c.src       = SRC_XTAL;
                c.wait_kind = WAIT_OST;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/osc_mode_latch.sv
module osc_mode_latch
    import osc_clkctl_pkg::*;
(
    input  logic              ref_clk,
    input  logic              por_n,
    input  logic [MODE_W-1:0] cfg_mode,
    output mode_cfg_t         cfg
);

    logic [MODE_W-1:0] mode_q;

    // Capture while reset is held; frozen afterwards.
    always_ff @(posedge ref_clk) begin
        if (!por_n) begin
            mode_q <= cfg_mode;
        end
    end

    always_comb begin
        cfg = decode_mode(mode_q);
    end

    // R1: captured mode holds once reset is released
    p_mode_frozen_r1: assert property (@(posedge ref_clk) disable iff (!por_n)
        por_n |=> $stable(mode_q));

endmodule

// File: rtl/osc_start_seq.sv
module osc_start_seq
    import osc_clkctl_pkg::*;
#(
    parameter int OST_CYCLES  = 64,
    parameter int LOCK_CYCLES = 128
) (
    input  logic        ref_clk,
    input  logic        por_n,
    input  start_wait_e wait_kind,
    input  logic        sleep_req,
    input  logic        wake_evt,
    input  logic        pll_locked,
    output logic        run_en
);

    localparam int CNT_MAX = (OST_CYCLES > LOCK_CYCLES) ? OST_CYCLES : LOCK_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] OST_LAST  = CNT_W'(OST_CYCLES - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // State register
    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_RESET;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_RESET, ST_SLEEP: begin
                if (state == ST_RESET || wake_evt) begin
                    cnt_nx = '0;
                    unique case (wait_kind)
                        WAIT_NONE: state_nx = ST_RUN;
                        WAIT_LOCK: state_nx = ST_LOCK_WAIT;
                        default:   state_nx = ST_OST_WAIT;
                    endcase
                end
            end
            ST_OST_WAIT: begin
                if (cnt == OST_LAST) begin
                    state_nx = ST_RUN;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            ST_LOCK_WAIT: begin
                if (cnt != LOCK_LAST) begin
                    cnt_nx = cnt + CNT_W'(1);
                end else if (pll_locked) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (sleep_req) begin
                    state_nx = ST_SLEEP;
                end
            end
            default: state_nx = ST_RESET;
        endcase
    end

    // Outputs
    always_comb begin
        run_en = (state == ST_RUN);
    end

    // R10: no execution under reset
    p_reset_holds_r10: assert property (@(posedge ref_clk)
        !por_n |=> !run_en);

    // R6: external-clock wake runs on the next edge
    p_ext_no_wait_r6: assert property (@(posedge ref_clk) disable iff (!por_n)
        (state == ST_SLEEP && wake_evt && wait_kind == WAIT_NONE) |=> run_en);

    // R7: start-up count gates execution
    p_ost_gates_r7: assert property (@(posedge ref_clk) disable iff (!por_n)
        (state == ST_OST_WAIT && cnt != OST_LAST) |=> !run_en);

    // R8: missing lock keeps execution held
    p_lock_gates_r8: assert property (@(posedge ref_clk) disable iff (!por_n)
        (state == ST_LOCK_WAIT && !pll_locked) |=> !run_en);

    // R9: sleep request stops execution
    p_sleep_drops_r9: assert property (@(posedge ref_clk) disable iff (!por_n)
        (run_en && sleep_req) |=> !run_en);

    // R11: only a sleep request leaves the run state
    p_run_sticky_r11: assert property (@(posedge ref_clk) disable iff (!por_n)
        (run_en && !sleep_req) |=> run_en);

endmodule

// File: rtl/osc_clk_div4.sv
module osc_clk_div4 #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic q
);

    logic [SYNC_STAGES-1:0] rst_pipe;
    logic                   srst;
    logic [DIV_W-1:0]       cnt;

    // Reset released in this clock's domain
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rst_pipe <= '1;
        end else begin
            rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b0};
        end
    end

    assign srst = rst_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (srst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    assign q = cnt[DIV_W-1];

    // R4: every high phase lasts at least two cycles
    p_half_period_r4: assert property (@(posedge clk) disable iff (srst)
        $rose(q) |=> q);

endmodule

// File: rtl/osc_mode_clkctl.sv
module osc_mode_clkctl
    import osc_clkctl_pkg::*;
#(
    parameter int OST_CYCLES  = 64,
    parameter int LOCK_CYCLES = 128
) (
    input  logic       ref_clk,
    input  logic       por_n,
    input  logic [2:0] cfg_mode,
    input  logic       clk_ext,
    input  logic       clk_xtal,
    input  logic       clk_pll,
    input  logic       pll_locked,
    input  logic       sleep_req,
    input  logic       wake_evt,
    output logic       core_clk,
    output logic       osc2_clk,
    output logic       osc2_is_gpio,
    output logic       pll_en,
    output logic       run_en
);

    mode_cfg_t cfg;
    logic      div_q;

    osc_mode_latch u_latch (
        .ref_clk  (ref_clk),
        .por_n    (por_n),
        .cfg_mode (cfg_mode),
        .cfg      (cfg)
    );

    osc_start_seq #(
        .OST_CYCLES  (OST_CYCLES),
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_seq (
        .ref_clk    (ref_clk),
        .por_n      (por_n),
        .wait_kind  (cfg.wait_kind),
        .sleep_req  (sleep_req),
        .wake_evt   (wake_evt),
        .pll_locked (pll_locked),
        .run_en     (run_en)
    );

    always_comb begin
        unique case (cfg.src)
            SRC_EXT: core_clk = clk_ext;
            SRC_PLL: core_clk = clk_pll;
            default: core_clk = clk_xtal;
        endcase
    end

    osc_clk_div4 u_div (
        .clk    (core_clk),
        .arst_n (por_n),
        .q      (div_q)
    );

    assign osc2_clk     = cfg.osc2_clkout & div_q;
    assign osc2_is_gpio = cfg.osc2_gpio;
    assign pll_en       = cfg.pll_en;

    // R5: pin handed to I/O never carries the clock
    p_gpio_quiet_r5: assert property (@(posedge ref_clk) disable iff (!por_n)
        osc2_is_gpio |-> !osc2_clk);

    // R3: PLL enable only with the PLL as source
    p_pll_only_r3: assert property (@(posedge ref_clk) disable iff (!por_n)
        pll_en |-> (cfg.src == SRC_PLL));

endmodule

// File: tb/osc_mode_clkctl_test.sv
`timescale 1ns/10ps
module osc_mode_clkctl_test;

    localparam int OST  = 64;
    localparam int LOCK = 128;

    logic ref_clk = 0, clk_ext = 0, clk_xtal = 0, clk_pll = 0;
    always #2.5 ref_clk  = ~ref_clk;
    always #4   clk_ext  = ~clk_ext;
    always #8   clk_xtal = ~clk_xtal;
    always #2   clk_pll  = ~clk_pll;

    logic       por_n = 0, sleep_req = 0, wake_evt = 0, pll_locked = 1;
    logic [2:0] cfg_mode = 3'b001;
    logic       core_clk, osc2_clk, osc2_is_gpio, pll_en, run_en;

    osc_mode_clkctl #(.OST_CYCLES(OST), .LOCK_CYCLES(LOCK)) uut (
        .ref_clk(ref_clk), .por_n(por_n), .cfg_mode(cfg_mode),
        .clk_ext(clk_ext), .clk_xtal(clk_xtal), .clk_pll(clk_pll),
        .pll_locked(pll_locked), .sleep_req(sleep_req), .wake_evt(wake_evt),
        .core_clk(core_clk), .osc2_clk(osc2_clk), .osc2_is_gpio(osc2_is_gpio),
        .pll_en(pll_en), .run_en(run_en)
    );

    int  tests = 0, fails = 0;
    bit  arm = 0, done = 0, finished = 0;

    typedef struct { string req; int lat; } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measures run_en latency and scores it against the queue
    initial forever begin
        int   n;
        exp_t e;
        wait (arm);
        arm = 0;
        n = 0;
        while (!run_en && n < 4000) begin
            @(posedge ref_clk);
            @(negedge ref_clk);
            n++;
        end
        e = exp_q.pop_front();
        check(n == e.lat, e.req, n, e.lat);
        done = 1;
    end

    task automatic start_por(input logic [2:0] mode, input string req, input int lat);
        @(negedge ref_clk);
        por_n = 0;
        cfg_mode = mode;
        repeat (4) @(negedge ref_clk);
        check(run_en == 0, "R10 run_en under reset", int'(run_en), 0);
        check(osc2_clk == 0, "R4 osc2_clk under reset", int'(osc2_clk), 0);
        exp_q.push_back('{req, lat});
        por_n = 1;
        arm = 1;
    endtask

    task automatic start_wake(input string req, input int lat);
        @(negedge ref_clk); sleep_req = 1;
        @(negedge ref_clk); sleep_req = 0;
        check(run_en == 0, "R9 sleep drops run_en", int'(run_en), 0);
        @(negedge ref_clk); sleep_req = 1;
        @(negedge ref_clk); sleep_req = 0;
        @(negedge ref_clk);
        check(run_en == 0, "R11 sleep_req while asleep", int'(run_en), 0);
        exp_q.push_back('{req, lat});
        wake_evt = 1;
        arm = 1;
        @(negedge ref_clk); wake_evt = 0;
    endtask

    task automatic wait_done();
        wait (done);
        done = 0;
        @(negedge ref_clk);
    endtask

    // sel: 0 ext, 1 xtal, 2 pll
    task automatic check_src(input int sel, input string req);
        int   bad = 0;
        logic e;
        @(negedge ref_clk);
        #0.25;
        for (int i = 0; i < 40; i++) begin
            e = (sel == 0) ? clk_ext : (sel == 1) ? clk_xtal : clk_pll;
            if (core_clk !== e) bad++;
            #1;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic check_div(input string req);
        logic prev, cur, e;
        int   bad = 0, found = 0;
        @(negedge clk_ext);
        prev = osc2_clk;
        for (int i = 0; i < 20 && found == 0; i++) begin
            @(negedge clk_ext);
            cur = osc2_clk;
            if (!prev && cur) found = 1;
            prev = cur;
        end
        check(found == 1, "R4 osc2_clk rises", found, 1);
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk_ext);
            e = ((i % 4) == 0) || ((i % 4) == 1);
            if (osc2_clk !== e) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic check_osc2_low(input string req);
        int bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_ext);
            if (osc2_clk !== 1'b0) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic check_run_holds(input string req);
        int bad = 0;
        @(negedge ref_clk); wake_evt = 1;
        @(negedge ref_clk); wake_evt = 0;
        for (int i = 0; i < 8; i++) begin
            if (!run_en) bad++;
            @(negedge ref_clk);
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        // Crystal, high range
        start_por(3'b001, "R7 crystal start-up latency", OST + 1);
        wait_done();
        check_src(1, "R2 crystal source");
        check(pll_en == 0, "R3 pll_en off in crystal mode", int'(pll_en), 0);
        check(osc2_is_gpio == 0, "R5 no gpio in crystal mode", int'(osc2_is_gpio), 0);
        check_osc2_low("R5 osc2_clk low in crystal mode");
        check_run_holds("R11 wake while running");
        start_wake("R9 crystal wake latency", OST + 1);
        wait_done();

        // External clock with clock out
        start_por(3'b100, "R6 ext start-up latency", 1);
        wait_done();
        check_src(0, "R2 external source");
        check_div("R4 divide-by-four pattern");
        check(osc2_is_gpio == 0, "R5 no gpio with clock out", int'(osc2_is_gpio), 0);
        cfg_mode = 3'b101;
        repeat (5) @(negedge ref_clk);
        check(osc2_is_gpio == 0, "R1 late mode change ignored (gpio)", int'(osc2_is_gpio), 0);
        cfg_mode = 3'b010;
        repeat (5) @(negedge ref_clk);
        check(pll_en == 0, "R1 late mode change ignored (pll_en)", int'(pll_en), 0);
        check_src(0, "R1 late mode change ignored (source)");
        start_wake("R6 ext wake latency", 1);
        wait_done();

        // External clock with I/O pin
        start_por(3'b101, "R6 ext-gpio start-up latency", 1);
        wait_done();
        check(osc2_is_gpio == 1, "R5 gpio in ext-gpio mode", int'(osc2_is_gpio), 1);
        check_osc2_low("R5 osc2_clk low in ext-gpio mode");
        check_src(0, "R2 external source, gpio mode");

        // PLL, lock present
        pll_locked = 1;
        start_por(3'b010, "R8 pll start-up latency", LOCK + 1);
        wait_done();
        check_src(2, "R2 pll source");
        check(pll_en == 1, "R3 pll_en on in pll mode", int'(pll_en), 1);
        start_wake("R8 pll wake latency", LOCK + 1);
        wait_done();

        // PLL, lock withheld past the count
        pll_locked = 0;
        start_por(3'b010, "R8 pll late-lock latency", LOCK + 21);
        repeat (LOCK + 20) @(negedge ref_clk);
        check(run_en == 0, "R8 held without lock", int'(run_en), 0);
        pll_locked = 1;
        wait_done();

        // Unused code and low-range crystal
        start_por(3'b111, "R7 unused code latency", OST + 1);
        wait_done();
        check_src(1, "R2 unused code uses crystal");
        check(pll_en == 0, "R3 pll_en off for unused code", int'(pll_en), 0);
        start_por(3'b000, "R7 low crystal latency", OST + 1);
        wait_done();
        check_src(1, "R2 low crystal source");

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule